// File: doc/BRIEF.md
# Read Prefetch Boundary Controller

This block sits beside the master side of a bus bridge that forwards reads from one bus to another. When a read is about to be issued on the target bus, the master side pulses a start strobe with the bus command, a flag saying whether the address falls in prefetchable memory, the programmed cache line size and the starting DWORD address. From these the block works out a power-of-two burst window. It then loads a remaining-phase count equal to the distance from the start address to the end of that aligned window.

While the read runs, each data phase that the target accepts advances an internal DWORD address and lowers the count. The block raises a stop request during the last data phase the window permits, so the master side can end the burst without crossing the boundary. Reads that may not prefetch get a one-DWORD window, so the stop request is already high on their first phase.

Control is a three-state machine. IDLE is the state after reset. RUN holds while phases remain. DONE is entered after the final permitted phase. The named transitions are LAUNCH (IDLE or DONE to RUN on start), RELOAD (RUN to RUN on start), FINISH (RUN to DONE on the accepted last phase) and HOLD (remaining in any state without start).

Top module: `rpb_ctrl`

## Requirements
- R1: A configuration read (command 4'hA) or an I/O read (command 4'h2) gets a window of exactly 1 DWORD, whatever the prefetchable flag and line size are.
- R2: A memory read (command 4'h6) with the prefetchable flag low gets a 1-DWORD window. Any command other than 4'h2, 4'hA, 4'h6, 4'hE or 4'hC also gets a 1-DWORD window.
- R3: A memory read with the prefetchable flag high, or a memory read line (command 4'hE), gets a window equal to the line size when the line size is 1, 2, 4 or 8.
- R4: The reads named in R3 get a 16-DWORD window when the line size is 0 or 16.
- R5: A memory read multiple (command 4'hC) gets a window of twice the line size when the line size is 1, 2, 4 or 8, and a 32-DWORD window when it is 0 or 16.
- R6: For memory read line and memory read multiple, the prefetchable flag has no effect on the window.
- R7: A line size outside {0, 1, 2, 4, 8, 16} behaves exactly like 0.
- R8: In the cycle after start, window_o holds the window W, cur_addr_o holds the start address, remain_o holds W minus (start address mod W), and busy_o is high.
- R9: Each cycle in RUN with phase_ack_i high raises cur_addr_o by 1 and lowers remain_o by 1. Without phase_ack_i, both stay unchanged.
- R10: stop_o is high exactly when busy_o is high and remain_o equals 1, which is the cycle of the last permitted data phase.
- R11: After the last permitted phase is accepted, busy_o and stop_o are low and remain_o is 0. Further phase_ack_i pulses leave cur_addr_o and remain_o unchanged.
- R12: A start pulse during RUN reloads all state from the new inputs. Reset clears cur_addr_o, remain_o and window_o to 0 and busy_o to low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle strobe that loads a new read |
| cmd_i | input | 4 | Bus command of the read |
| pref_i | input | 1 | Start address lies in prefetchable memory |
| cls_i | input | CLS_W (8) | Programmed cache line size in DWORDs |
| addr_i | input | ADDR_W (30) | Starting DWORD address |
| phase_ack_i | input | 1 | A data phase was accepted this cycle |
| busy_o | output | 1 | A read window is open (state RUN) |
| stop_o | output | 1 | Current phase is the last one permitted |
| cur_addr_o | output | ADDR_W (30) | DWORD address of the current phase |
| remain_o | output | CNT_W (6) | Data phases still permitted |
| window_o | output | CNT_W (6) | Window size chosen at start |

## Verification
All results are registered on the rising edge that samples their cause. The window, address and count for a start are visible one cycle after the start strobe, and each accepted phase shows up one cycle after its acknowledge. stop_o is a function of registered state only, so it is valid throughout the cycle in which the last phase is offered. The bench drives inputs on the falling edge and compares outputs at the next falling edge, after exactly one rising edge. It tracks the expected count and address itself, one acknowledge at a time.

// File: rtl/rpb_pkg.sv
package rpb_pkg;

    // Bus command codes used to pick a window rule
    localparam logic [3:0] CMD_IO_RD   = 4'h2;
    localparam logic [3:0] CMD_MEM_RD  = 4'h6;
    localparam logic [3:0] CMD_CFG_RD  = 4'hA;
    localparam logic [3:0] CMD_MEM_RDM = 4'hC;
    localparam logic [3:0] CMD_MEM_RDL = 4'hE;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } rpb_state_e;

endpackage

// File: rtl/rpb_window_calc.sv
module rpb_window_calc
    import rpb_pkg::*;
#(
    parameter int CLS_W         = 8,
    parameter int ADDR_W        = 30,
    parameter int FALLBACK_LINE = 16,
    parameter int CNT_W         = $clog2(2 * FALLBACK_LINE) + 1
) (
    input  logic [3:0]        cmd_i,
    input  logic              pref_i,
    input  logic [CLS_W-1:0]  cls_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [CNT_W-1:0]  win_o,
    output logic [CNT_W-1:0]  init_o
);

    logic             line_ok;
    logic [CNT_W-1:0] line_sz;
    logic [CNT_W-1:0] offset;

    // Supported line sizes: non-zero powers of two below the fallback size
    always_comb begin
        line_ok = (cls_i != '0)
               && ((cls_i & (cls_i - 1'b1)) == '0)
               && (cls_i < CLS_W'(FALLBACK_LINE));
        line_sz = line_ok ? CNT_W'(cls_i) : CNT_W'(FALLBACK_LINE);
    end

    always_comb begin
        case (cmd_i)
            CMD_IO_RD,
            CMD_CFG_RD:  win_o = CNT_W'(1);
            CMD_MEM_RD:  win_o = pref_i ? line_sz : CNT_W'(1);
            CMD_MEM_RDL: win_o = line_sz;
            CMD_MEM_RDM: win_o = line_sz << 1;
            default:     win_o = CNT_W'(1);
        endcase
    end

    // Window is a power of two: offset inside it is a mask of the low bits
    always_comb begin
        offset = addr_i[CNT_W-1:0] & (win_o - 1'b1);
        init_o = win_o - offset;
    end

endmodule

// File: rtl/rpb_fsm.sv
module rpb_fsm
    import rpb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic ack_i,
    input  logic last_i,
    output logic load_o,
    output logic step_o,
    output logic busy_o,
    output logic stop_o
);

    rpb_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_i) state_d = ST_RUN;                // LAUNCH
            ST_RUN: begin
                if (start_i)             state_d = ST_RUN;         // RELOAD
                else if (ack_i && last_i) state_d = ST_DONE;       // FINISH
            end
            ST_DONE: if (start_i) state_d = ST_RUN;                // LAUNCH
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        load_o = start_i;
        busy_o = (state_q == ST_RUN);
        step_o = busy_o && ack_i && !start_i;
        stop_o = busy_o && last_i;
    end

endmodule

// File: rtl/rpb_phase_counter.sv
module rpb_phase_counter #(
    parameter int ADDR_W = 30,
    parameter int CNT_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              step_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [CNT_W-1:0]  win_i,
    input  logic [CNT_W-1:0]  init_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic [CNT_W-1:0]  remain_o,
    output logic [CNT_W-1:0]  win_o,
    output logic              last_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_o   <= '0;
            remain_o <= '0;
            win_o    <= '0;
        end else if (load_i) begin
            addr_o   <= addr_i;
            remain_o <= init_i;
            win_o    <= win_i;
        end else if (step_i) begin
            addr_o   <= addr_o + 1'b1;
            remain_o <= remain_o - 1'b1;
        end
    end

    assign last_o = (remain_o == CNT_W'(1));

endmodule

// File: rtl/rpb_ctrl.sv
module rpb_ctrl #(
    parameter int CLS_W         = 8,
    parameter int ADDR_W        = 30,
    parameter int FALLBACK_LINE = 16,
    parameter int CNT_W         = $clog2(2 * FALLBACK_LINE) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [3:0]        cmd_i,
    input  logic              pref_i,
    input  logic [CLS_W-1:0]  cls_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              phase_ack_i,
    output logic              busy_o,
    output logic              stop_o,
    output logic [ADDR_W-1:0] cur_addr_o,
    output logic [CNT_W-1:0]  remain_o,
    output logic [CNT_W-1:0]  window_o
);

    logic [CNT_W-1:0] win_w, init_w;
    logic             load_w, step_w, last_w;

    rpb_window_calc #(
        .CLS_W(CLS_W), .ADDR_W(ADDR_W),
        .FALLBACK_LINE(FALLBACK_LINE), .CNT_W(CNT_W)
    ) u_calc (
        .cmd_i(cmd_i), .pref_i(pref_i), .cls_i(cls_i), .addr_i(addr_i),
        .win_o(win_w), .init_o(init_w)
    );

    rpb_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .ack_i(phase_ack_i),
        .last_i(last_w), .load_o(load_w), .step_o(step_w),
        .busy_o(busy_o), .stop_o(stop_o)
    );

    rpb_phase_counter #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .load_i(load_w), .step_i(step_w),
        .addr_i(addr_i), .win_i(win_w), .init_i(init_w),
        .addr_o(cur_addr_o), .remain_o(remain_o), .win_o(window_o),
        .last_o(last_w)
    );

endmodule

// File: rtl/rpb_ctrl_chk.sv
module rpb_ctrl_chk #(
    parameter int ADDR_W = 30,
    parameter int CNT_W  = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              phase_ack_i,
    input logic              busy_o,
    input logic              stop_o,
    input logic [ADDR_W-1:0] cur_addr_o,
    input logic [CNT_W-1:0]  remain_o,
    input logic [CNT_W-1:0]  window_o
);

    // R10: stop only on the last permitted phase of an open window
    p_stop_last_r10: assert property (@(posedge clk) disable iff (!rst_n)
        stop_o |-> (busy_o && remain_o == CNT_W'(1)));

    p_stop_when_last_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && remain_o == CNT_W'(1)) |-> stop_o);

    // R9: an accepted phase moves address and count by one
    p_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && phase_ack_i && !start_i) |=>
            (remain_o == $past(remain_o) - 1'b1 && cur_addr_o == $past(cur_addr_o) + 1'b1));

    // R9: no acknowledge, no movement
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!phase_ack_i && !start_i) |=> ($stable(remain_o) && $stable(cur_addr_o)));

    // R11: last phase accepted closes the window
    p_finish_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_o && phase_ack_i && !start_i) |=> (!busy_o && remain_o == '0));

    // R11: closed window is quiet
    p_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> ($stable(cur_addr_o) && $stable(remain_o)));

    // R8: after a start the window is a power of two covering the count
    p_window_r8: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (busy_o && $countones(window_o) == 1
                     && remain_o != '0 && remain_o <= window_o));

endmodule

bind rpb_ctrl rpb_ctrl_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/rpb_ctrl_tb_top.sv
module rpb_ctrl_tb_top;

    localparam int ADDR_W = 30;
    localparam int CNT_W  = 6;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start_i = 1'b0;
    logic [3:0]        cmd_i = '0;
    logic              pref_i = 1'b0;
    logic [7:0]        cls_i = '0;
    logic [ADDR_W-1:0] addr_i = '0;
    logic              phase_ack_i = 1'b0;
    logic              busy_o, stop_o;
    logic [ADDR_W-1:0] cur_addr_o;
    logic [CNT_W-1:0]  remain_o, window_o;

    int n_chk = 0;
    int n_bad = 0;
    int cycles = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    rpb_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .cmd_i(cmd_i),
        .pref_i(pref_i), .cls_i(cls_i), .addr_i(addr_i),
        .phase_ack_i(phase_ack_i), .busy_o(busy_o), .stop_o(stop_o),
        .cur_addr_o(cur_addr_o), .remain_o(remain_o), .window_o(window_o)
    );

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int exp_win(input int c, input bit p, input int cl);
        int ln;
        ln = (cl == 1 || cl == 2 || cl == 4 || cl == 8) ? cl : 16;
        case (c)
            2, 10:   return 1;
            6:       return p ? ln : 1;
            14:      return ln;
            12:      return 2 * ln;
            default: return 1;
        endcase
    endfunction

    function automatic string win_req(input int c, input bit p, input int cl);
        bit ok;
        ok = (cl == 1 || cl == 2 || cl == 4 || cl == 8);
        if (c == 2 || c == 10) return "R1";
        if (c == 6 && !p) return "R2";
        if (c == 12) return "R5";
        if (c == 6 || c == 14) return ok ? "R3" : (cl == 0 || cl == 16) ? "R4" : "R7";
        return "R2";
    endfunction

    task automatic launch(input int c, input bit p, input int cl, input int a);
        @(negedge clk);
        start_i = 1'b1; cmd_i = 4'(c); pref_i = p; cls_i = 8'(cl);
        addr_i = ADDR_W'(a); phase_ack_i = 1'b0;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic run_one(input int c, input bit p, input int cl, input int a, input int seed);
        int w, r, ad, k;
        w  = exp_win(c, p, cl);
        r  = w - (a % w);
        ad = a;
        launch(c, p, cl, a);
        chk(win_req(c, p, cl), "window", window_o, w);
        if (c == 12 || c == 14) chk("R6", "window vs flag", window_o, exp_win(c, !p, cl));
        if (cl == 3 || cl == 32 || cl == 255) chk("R7", "window odd cls", window_o, exp_win(c, p, 0));
        chk("R8", "remain", remain_o, r);
        chk("R8", "addr", cur_addr_o, ad);
        chk("R8", "busy", busy_o, 1);
        k = 0;
        while (r > 0) begin
            chk("R10", "stop", stop_o, (r == 1));
            phase_ack_i = ((k + seed) % 3) != 0;
            @(negedge clk);
            if (phase_ack_i) begin r--; ad++; end
            chk("R9", "remain step", remain_o, r);
            chk("R9", "addr step", cur_addr_o, ad);
            k++;
        end
        phase_ack_i = 1'b0;
        chk("R11", "busy after last", busy_o, 0);
        chk("R11", "stop after last", stop_o, 0);
        phase_ack_i = 1'b1;
        @(negedge clk);
        phase_ack_i = 1'b0;
        chk("R11", "addr ignored ack", cur_addr_o, ad);
        chk("R11", "remain ignored ack", remain_o, 0);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000 && !finished) begin
                n_bad++;
                $display("FAIL watchdog: actual %0d expected <150000 cycles", cycles);
                $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
                $finish;
            end
        end
    end

    initial begin
        int cmds[6] = '{2, 10, 6, 14, 12, 7};
        int clss[9] = '{0, 1, 2, 3, 4, 8, 16, 32, 255};
        int offs[8] = '{0, 1, 5, 15, 16, 31, 33, 62};
        int seed;
        seed = 0;
        repeat (3) @(negedge clk);
        chk("R12", "reset busy", busy_o, 0);
        chk("R12", "reset remain", remain_o, 0);
        chk("R12", "reset window", window_o, 0);
        chk("R12", "reset addr", cur_addr_o, 0);
        rst_n = 1'b1;

        foreach (cmds[i]) foreach (clss[j]) for (int p = 0; p < 2; p++)
            foreach (offs[m]) begin
                run_one(cmds[i], p[0], clss[j], 32'h3F00 + offs[m], seed);
                seed++;
            end

        // R12: restart in mid run
        launch(12, 1'b0, 0, 32'h100);
        phase_ack_i = 1'b1;
        repeat (3) @(negedge clk);
        phase_ack_i = 1'b0;
        chk("R12", "pre-reload remain", remain_o, 29);
        launch(10, 1'b1, 8, 32'h207);
        chk("R12", "reload window", window_o, 1);
        chk("R12", "reload remain", remain_o, 1);
        chk("R12", "reload addr", cur_addr_o, 32'h207);
        chk("R12", "reload stop", stop_o, 1);

        // R12: reset in mid run
        launch(14, 1'b0, 0, 32'h40);
        rst_n = 1'b0;
        #1;
        chk("R12", "mid reset busy", busy_o, 0);
        chk("R12", "mid reset remain", remain_o, 0);
        chk("R12", "mid reset addr", cur_addr_o, 0);
        @(negedge clk);
        rst_n = 1'b1;

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule